// File: doc/BRIEF.md
# Page Write Buffer Controller

This block sits behind the serial protocol engine of a small byte-wide nonvolatile memory. Once the engine has decoded a write command and its word address, it signals a write start together with that base address. Each data byte that follows is staged in a page-sized buffer. The buffer slot is chosen by a page offset that counts up from the base and wraps inside the page. A slot that is written again simply takes the newer byte. Nothing reaches the array until the engine reports a stop.

On that stop, only the slots that actually received data are copied into the array, one byte per clock through a single write port. A busy flag rises on the cycle after the stop and stays high for a programmable number of clock cycles, which models the write-cycle time. While busy is high, the block ignores all requests.

The shared address pointer is reloaded on every stop. It points just past the last byte written, within the page, unless a full page or more was sent, in which case it returns to the base. A write-protect level seen at any moment of the transfer cancels the array update.

Top module: `pwb_ctrl`

## Requirements
- R1: After reset, busy_o is 0, ptr_o is 0 and mem_we_o is 0.
- R2: Consecutive data bytes go to consecutive page offsets, starting at the low PAGE_W bits of the base. The offset wraps from the last offset of the page to offset 0. Every array write keeps the upper ADDR_W-PAGE_W address bits of the base.
- R3: When more bytes are sent than the page holds, a location that receives data twice ends up holding the byte received last.
- R4: Only locations that received a byte are written. All other array locations, inside and outside the page, keep their old contents.
- R5: No array write and no busy period happens before the stop strobe that ends the transfer.
- R6: A committing stop raises busy_o on the next cycle, and busy_o then stays high for exactly BUSY_CYCLES cycles. Every array write happens while busy_o is high.
- R7: After a stop with 1 to PAGE_BYTES-1 bytes, ptr_o holds the base page with offset (base offset + byte count) mod PAGE_BYTES.
- R8: After a stop with PAGE_BYTES or more bytes, ptr_o equals the base. A single byte written at the last offset of a page leaves ptr_o at offset 0 of that page.
- R9: If wp_i is 1 in any cycle from the start through the stop, the array is left unchanged and busy_o stays 0. ptr_o still follows R7 and R8.
- R10: A stop with no data bytes writes nothing and starts no busy period. It sets ptr_o to the base.
- R11: While busy_o is 1, wr_start_i, byte_vld_i and stop_i have no effect on the array, ptr_o or the busy length.
- R12: byte_vld_i and stop_i have no effect when no transfer has been started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_start_i | input | 1 | One-cycle strobe: a write transfer begins |
| wr_base_i | input | ADDR_W | Word address of the first data byte |
| byte_vld_i | input | 1 | One-cycle strobe: byte_i holds a data byte |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | One-cycle strobe: the transfer has ended |
| wp_i | input | 1 | Write-protect level |
| busy_o | output | 1 | Write cycle in progress |
| ptr_o | output | ADDR_W | Address pointer left by the last transfer |
| mem_we_o | output | 1 | Array write enable |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |

## Verification
The assertions assume that wr_start_i and stop_i are never asserted in the same cycle. They also assume that BUSY_CYCLES is at least PAGE_BYTES+1, so that the serial commit finishes inside the busy window. The bench drives inputs on the falling clock edge, with at most one strobe per cycle, and never pairs a start with a stop. It runs with a short busy count that meets that bound. The stimulus sent while busy is high and while the block is idle is legal on the bus; only its timing makes the block ignore it.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_COLLECT = 1'b1
  } pwb_state_e;
endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
  parameter int PAGE_W = 4,
  parameter int DATA_W = 8,
  localparam int PAGE_BYTES = 1 << PAGE_W
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   clr_i,
  input  logic                                   wr_i,
  input  logic [PAGE_W-1:0]                      off_i,
  input  logic [DATA_W-1:0]                      data_i,
  output logic [PAGE_BYTES-1:0]                  mask_o,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]      data_o
);
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_i && (off_i == PAGE_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mask_o[g] <= 1'b0;
        data_o[g] <= '0;
      end else if (clr_i) begin
        mask_o[g] <= 1'b0;
      end else if (hit) begin
        mask_o[g] <= 1'b1;
        data_o[g] <= data_i;
      end
    end
  end
endmodule

// File: rtl/pwb_commit_seq.sv
module pwb_commit_seq #(
  parameter int PAGE_W = 4,
  parameter int HI_W   = 4,
  parameter int DATA_W = 8,
  localparam int PAGE_BYTES = 1 << PAGE_W,
  localparam int ADDR_W     = HI_W + PAGE_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              start_i,
  input  logic [HI_W-1:0]                   page_i,
  input  logic [PAGE_BYTES-1:0]             mask_i,
  input  logic [PAGE_BYTES-1:0][DATA_W-1:0] data_i,
  output logic                              we_o,
  output logic [ADDR_W-1:0]                 addr_o,
  output logic [DATA_W-1:0]                 wdata_o
);
  logic              active_q;
  logic [PAGE_W-1:0] idx_q;
  logic [HI_W-1:0]   page_q;
  logic              last;

  assign last = (idx_q == PAGE_W'(PAGE_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      page_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      page_q   <= page_i;
    end else if (active_q) begin
      idx_q <= idx_q + 1'b1;
      if (last) active_q <= 1'b0;
    end
  end

  // one slot per cycle; unreceived slots produce no write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= active_q && mask_i[idx_q];
      if (active_q) begin
        addr_o  <= {page_q, idx_q};
        wdata_o <= data_i[idx_q];
      end
    end
  end
endmodule

// File: rtl/pwb_busy_timer.sv
module pwb_busy_timer #(
  parameter int BUSY_CYCLES = 1000000,
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      busy_o <= 1'b1;
      cnt_q  <= CNT_W'(BUSY_CYCLES - 1);
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_start_i,
  input  logic [ADDR_W-1:0] wr_base_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  input  logic              wp_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int HI_W       = ADDR_W - PAGE_W;
  localparam int CNT_W      = PAGE_W + 1;

  pwb_state_e        st_q;
  logic [ADDR_W-1:0] base_q;
  logic [PAGE_W-1:0] off_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wp_seen_q;

  logic in_collect, accept_start, take_byte, end_xfer, protect, do_commit, full;
  logic [PAGE_BYTES-1:0]             buf_mask;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] buf_data;

  assign in_collect   = (st_q == ST_COLLECT);
  assign accept_start = wr_start_i && !busy_o;
  assign take_byte    = in_collect && !wr_start_i && !stop_i && byte_vld_i;
  assign end_xfer     = in_collect && !wr_start_i && stop_i;
  assign protect      = wp_seen_q || wp_i;
  assign full         = (cnt_q >= CNT_W'(PAGE_BYTES));
  assign do_commit    = end_xfer && !protect && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      base_q    <= '0;
      off_q     <= '0;
      cnt_q     <= '0;
      wp_seen_q <= 1'b0;
    end else if (accept_start) begin
      st_q      <= ST_COLLECT;
      base_q    <= wr_base_i;
      off_q     <= wr_base_i[PAGE_W-1:0];
      cnt_q     <= '0;
      wp_seen_q <= wp_i;
    end else if (end_xfer) begin
      st_q <= ST_IDLE;
    end else if (in_collect) begin
      wp_seen_q <= protect;
      if (take_byte) begin
        off_q <= off_q + 1'b1;
        if (!full) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // pointer: page-wrapped end offset, or base once a whole page was sent
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_o <= '0;
    else if (end_xfer) ptr_o <= full ? base_q : {base_q[ADDR_W-1:PAGE_W], off_q};
  end

  pwb_page_buf #(
    .PAGE_W (PAGE_W),
    .DATA_W (DATA_W)
  ) u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept_start),
    .wr_i   (take_byte),
    .off_i  (off_q),
    .data_i (byte_i),
    .mask_o (buf_mask),
    .data_o (buf_data)
  );

  pwb_commit_seq #(
    .PAGE_W (PAGE_W),
    .HI_W   (HI_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (do_commit),
    .page_i  (base_q[ADDR_W-1:PAGE_W]),
    .mask_i  (buf_mask),
    .data_i  (buf_data),
    .we_o    (mem_we_o),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o)
  );

  pwb_busy_timer #(
    .BUSY_CYCLES (BUSY_CYCLES)
  ) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (do_commit),
    .busy_o (busy_o)
  );
endmodule

// File: rtl/pwb_ctrl_chk.sv
module pwb_ctrl_chk #(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 4,
  parameter int BUSY_CYCLES = 1000000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_start_i,
  input logic [ADDR_W-1:0] wr_base_i,
  input logic              stop_i,
  input logic              wp_i,
  input logic              busy_o,
  input logic [ADDR_W-1:0] ptr_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic            col_q, wp_q;
  logic [HI_W-1:0] page_q;
  logic [31:0]     len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q  <= 1'b0;
      wp_q   <= 1'b0;
      page_q <= '0;
      len_q  <= '0;
    end else begin
      len_q <= busy_o ? len_q + 1 : 32'd0;
      if (wr_start_i && !busy_o) begin
        col_q  <= 1'b1;
        wp_q   <= wp_i;
        page_q <= wr_base_i[ADDR_W-1:PAGE_W];
      end else if (col_q && stop_i) begin
        col_q <= 1'b0;
      end else if (col_q) begin
        wp_q <= wp_q || wp_i;
      end
    end
  end

  AST_WE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o); // R6
  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (len_q == BUSY_CYCLES)); // R6
  AST_WE_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o[ADDR_W-1:PAGE_W] == page_q)); // R2
  AST_BUSY_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(stop_i) && $past(col_q))); // R5
  AST_NO_WE_COLLECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q |-> !mem_we_o); // R5
  AST_WP_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_q && stop_i && !wr_start_i && (wp_q || wp_i)) |=> !busy_o); // R9
  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(ptr_o)); // R11
endmodule

bind pwb_ctrl pwb_ctrl_chk #(
  .ADDR_W      (ADDR_W),
  .PAGE_W      (PAGE_W),
  .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_start_i (wr_start_i),
  .wr_base_i  (wr_base_i),
  .stop_i     (stop_i),
  .wp_i       (wp_i),
  .busy_o     (busy_o),
  .ptr_o      (ptr_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o)
);

// File: tb/pwb_ctrl_tb.sv
module pwb_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int PAGE_W     = 4;
  localparam int DATA_W     = 8;
  localparam int BC         = 40;
  localparam int PB         = 1 << PAGE_W;
  localparam int MEM_N      = 1 << ADDR_W;
  localparam int NVEC       = 10;

  // {base, byte count, wp mode (0 none, 1 whole transfer, 2 one-cycle pulse), data seed}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h20, 8'd1,  8'd0, 8'h11},
    {8'h3F, 8'd1,  8'd0, 8'h22},
    {8'h45, 8'd5,  8'd0, 8'h33},
    {8'h5C, 8'd6,  8'd0, 8'h44},
    {8'h60, 8'd16, 8'd0, 8'h55},
    {8'h73, 8'd20, 8'd0, 8'h66},
    {8'h80, 8'd4,  8'd1, 8'h77},
    {8'hA2, 8'd6,  8'd2, 8'h88},
    {8'hF8, 8'd15, 8'd0, 8'h99},
    {8'h46, 8'd2,  8'd0, 8'hAA}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_start = 1'b0;
  logic [ADDR_W-1:0] wr_base = '0;
  logic              byte_vld = 1'b0;
  logic [DATA_W-1:0] byte_d = '0;
  logic              stop = 1'b0;
  logic              wp = 1'b0;
  logic              busy;
  logic [ADDR_W-1:0] ptr;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  logic [DATA_W-1:0] arr [MEM_N];
  logic [DATA_W-1:0] exp_arr [MEM_N];
  logic [ADDR_W-1:0] exp_ptr;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic in_send = 1'b0, early_we = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwb_ctrl #(
    .ADDR_W      (ADDR_W),
    .PAGE_W      (PAGE_W),
    .DATA_W      (DATA_W),
    .BUSY_CYCLES (BC)
  ) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .wr_start_i  (wr_start),
    .wr_base_i   (wr_base),
    .byte_vld_i  (byte_vld),
    .byte_i      (byte_d),
    .stop_i      (stop),
    .wp_i        (wp),
    .busy_o      (busy),
    .ptr_o       (ptr),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata)
  );

  // register-array memory model fed by the write port
  always @(posedge clk) begin
    if (mem_we) arr[mem_addr] <= mem_wdata;
    if (mem_we && in_send) early_we <= 1'b1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_arr(input string req);
    int bad = 0;
    for (int i = 0; i < MEM_N; i++) if (arr[i] !== exp_arr[i]) bad++;
    check(req, bad, 0);
  endtask

  function automatic logic [DATA_W-1:0] dbyte(input logic [7:0] seed, input int i);
    return seed + DATA_W'(i * 7);
  endfunction

  task automatic send(input logic [7:0] base, input int n, input int mode, input logic [7:0] seed);
    @(negedge clk);
    wr_start = 1'b1; wr_base = base; wp = (mode == 1);
    in_send = 1'b1; early_we = 1'b0;
    @(negedge clk);
    wr_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_vld = 1'b1; byte_d = dbyte(seed, i);
      wp = (mode == 1) || (mode == 2 && i == n / 2);
      @(negedge clk);
    end
    byte_vld = 1'b0; wp = (mode == 1);
    stop = 1'b1; in_send = 1'b0;
  endtask

  task automatic wait_busy(output int cnt);
    cnt = 0;
    for (int k = 0; k < BC + 24; k++) begin
      @(negedge clk);
      if (k == 0) begin stop = 1'b0; wp = 1'b0; end
      if (busy) cnt++;
    end
  endtask

  task automatic model(input logic [7:0] base, input int n, input int mode, input logic [7:0] seed);
    for (int i = 0; i < n && mode == 0; i++)
      exp_arr[{base[7:4], 4'(base[3:0] + i)}] = dbyte(seed, i);
    exp_ptr = (n >= PB) ? base : {base[7:4], 4'(base[3:0] + n)};
  endtask

  initial begin
    int bcnt;
    for (int i = 0; i < MEM_N; i++) begin
      arr[i] = 8'(i) ^ 8'h5A;
      exp_arr[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 ptr", ptr, 0);
    check("R1 we", mem_we, 0);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R7 R8 R9 and R5/R6 per transfer
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] b, s;
      int n, m;
      b = VEC[v][31:24]; n = int'(VEC[v][23:16]); m = int'(VEC[v][15:8]); s = VEC[v][7:0];
      send(b, n, m, s);
      check("R5 no write before stop", early_we, 0);
      wait_busy(bcnt);
      model(b, n, m, s);
      check((m != 0) ? "R9 busy" : "R6 busy length", bcnt, (m != 0) ? 0 : BC);
      check((n >= PB || b[3:0] == 4'hF) ? "R8 ptr" : "R7 ptr", ptr, exp_ptr);
      check((n > PB) ? "R3 array" : (m != 0) ? "R9 array" : "R2 R4 array", 0, 0);
      n_chk--;
      check_arr((n > PB) ? "R3 array" : (m != 0) ? "R9 array" : "R2 R4 array");
    end

    // R10: stop straight after the address
    send(8'hC7, 0, 0, 8'h00);
    wait_busy(bcnt);
    check("R10 busy", bcnt, 0);
    check("R10 ptr", ptr, 8'hC7);
    check_arr("R10 array");

    // R11: a whole transfer issued while busy is ignored
    send(8'h93, 3, 0, 8'h31);
    model(8'h93, 3, 0, 8'h31);
    @(negedge clk);
    stop = 1'b0;
    check("R11 busy before", busy, 1);
    send(8'h10, 2, 0, 8'hE0);
    wait_busy(bcnt);
    check("R11 busy remainder", int'(bcnt < BC && bcnt > 0), 1);
    check("R11 ptr", ptr, 8'h96);
    check_arr("R11 array");

    // R12: byte and stop strobes while idle
    @(negedge clk);
    byte_vld = 1'b1; byte_d = 8'hFF;
    @(negedge clk);
    byte_vld = 1'b0; stop = 1'b1;
    wait_busy(bcnt);
    check("R12 busy", bcnt, 0);
    check("R12 ptr", ptr, 8'h96);
    check_arr("R12 array");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule